// File: doc/BRIEF.md
# Crossing-Indexed Keep/Drop Buffer

This block holds detector words grouped by the beam crossing they belong to until a verdict for that crossing arrives. Each word comes in tagged with its crossing number and is written into a slot chosen by the low bits of that number. Some time later a verdict arrives on a separate input. An accept queues the crossing for forwarding. An abort frees its slot at once and the data is lost.

Accepted crossings leave on a valid/ready stream, in the order their verdicts arrived. Each one is framed as a header word followed by its payload words. Slots have a fixed capacity. Words beyond that capacity are dropped, and a flag in the header records the loss.

Two more cases are handled. A word whose crossing already has a verdict is counted and thrown away. If backpressure holds an accepted crossing in its slot until a newer crossing maps onto the same slot, an error pulse is raised.

Top module: `xing_keep_buffer`

## Requirements
- R1: Words of crossing x are stored in slot x mod 2^SLOT_BITS. An accepted crossing's payload words are output in their arrival order.
- R2: An abort verdict discards the crossing: none of its words and no header reach the output.
- R3: A slot keeps at most WORDS_PER_SLOT words. Further words for that crossing are dropped, and header bit XING_W+CW (CW = clog2(WORDS_PER_SLOT+1)) is set to 1. That bit is 0 otherwise.
- R4: The header word has the crossing number in bits [XING_W-1:0], the stored word count in bits [XING_W+CW-1:XING_W] and zeros above the flag bit. out_sop is high only on the header. out_eop is high on the last payload word, or on the header itself when the count is zero.
- R5: Accepted crossings are output in the order their accept verdicts arrived, one complete frame after another.
- R6: A word whose crossing is equal to or older than the latest verdict is dropped, and late_count increments one cycle later. This includes a verdict for the same crossing in the same cycle.
- R7: While out_valid is high and out_ready is low, out_valid, out_data, out_sop and out_eop hold their values.
- R8: A slot is emptied when its crossing is aborted or fully forwarded. A later crossing mapping to that slot starts with a count of zero.
- R9: A word or verdict for a slot whose accepted crossing has not yet been fully forwarded is dropped, and reuse_err pulses one cycle later. The pending crossing's frame is unchanged.
- R10: After reset, out_valid, reuse_err and late_count are 0 and all slots are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data word present |
| in_xing | input | XING_W | Crossing number of the data word |
| in_data | input | DATA_W | Data word |
| dec_valid | input | 1 | Verdict present |
| dec_xing | input | XING_W | Crossing the verdict applies to |
| dec_accept | input | 1 | 1 = accept, 0 = abort |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can take a word |
| out_data | output | DATA_W | Header or payload word |
| out_sop | output | 1 | Marks the header word |
| out_eop | output | 1 | Marks the last word of a frame |
| late_count | output | LATE_W | Number of late words dropped (wraps) |
| reuse_err | output | 1 | One-cycle pulse on a blocked slot reuse |

## Verification
A stale word count or flag left in a slot would appear in the next header for that slot. This shows within one frame after a later crossing reuses the slot. A lost busy mark would let a new crossing overwrite pending words, and the next forwarded payload for that slot would carry the wrong words. A wrong verdict reference would change late_count in the cycle after the offending word. A broken hold under backpressure would alter out_data within a cycle of out_ready dropping.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;
  typedef enum logic [0:0] {FW_IDLE, FW_PAY} fw_state_e;
endpackage

// File: rtl/xbuf_slots.sv
// Slot storage: per-crossing word memory, counts, truncation flags and busy marks.
module xbuf_slots #(
  parameter int XW  = 8,
  parameter int DW  = 16,
  parameter int SB  = 4,
  parameter int WPS = 4,
  parameter int LW  = 16,
  localparam int CW = $clog2(WPS + 1),
  localparam int IW = $clog2(WPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [XW-1:0] in_xing,
  input  logic [DW-1:0] in_data,
  input  logic          dec_valid,
  input  logic [XW-1:0] dec_xing,
  input  logic          dec_accept,
  output logic          push_valid,
  output logic [XW-1:0] push_xing,
  input  logic [SB-1:0] rd_slot,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_word,
  output logic [CW-1:0] rd_count,
  output logic          rd_ovf,
  input  logic          free_valid,
  input  logic [SB-1:0] free_slot,
  output logic [LW-1:0] late_count,
  output logic          reuse_err
);
  localparam int NS = 1 << SB;

  logic [DW-1:0] mem [NS*WPS];
  logic [CW-1:0] cnt [NS];
  logic [NS-1:0] ovf, busy;
  logic          have_dec;
  logic [XW-1:0] last_dec;

  logic [XW-1:0] ref_x, diff;
  logic [SB-1:0] ds, is;
  logic          late, dec_blk, dec_abort_clr, dec_acc, in_blk, in_ok, in_full, wr;
  logic [CW-1:0] in_cnt;

  always_comb begin
    ref_x         = dec_valid ? dec_xing : last_dec;
    diff          = in_xing - ref_x;
    late          = in_valid && (dec_valid || have_dec) && (diff == '0 || diff[XW-1]);
    ds            = dec_xing[SB-1:0];
    is            = in_xing[SB-1:0];
    dec_blk       = dec_valid && busy[ds];
    dec_abort_clr = dec_valid && !dec_accept && !busy[ds];
    dec_acc       = dec_valid && dec_accept && !busy[ds];
    in_blk        = in_valid && !late && (busy[is] || (dec_acc && ds == is));
    in_ok         = in_valid && !late && !in_blk;
    in_cnt        = (dec_abort_clr && ds == is) ? '0 : cnt[is];
    in_full       = (in_cnt == CW'(WPS));
    wr            = in_ok && !in_full;
  end

  assign push_valid = dec_acc;
  assign push_xing  = dec_xing;
  assign rd_word    = mem[{rd_slot, rd_idx}];
  assign rd_count   = cnt[rd_slot];
  assign rd_ovf     = ovf[rd_slot];

  always_ff @(posedge clk) begin
    if (wr) mem[{is, in_cnt[IW-1:0]}] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) cnt[i] <= '0;
      ovf        <= '0;
      busy       <= '0;
      have_dec   <= 1'b0;
      last_dec   <= '0;
      late_count <= '0;
      reuse_err  <= 1'b0;
    end else begin
      reuse_err <= dec_blk || in_blk;
      if (late) late_count <= late_count + LW'(1);
      if (dec_valid) begin
        have_dec <= 1'b1;
        last_dec <= dec_xing;
      end
      if (dec_abort_clr) begin
        cnt[ds] <= '0;
        ovf[ds] <= 1'b0;
      end
      if (dec_acc) busy[ds] <= 1'b1;
      if (free_valid) begin
        busy[free_slot] <= 1'b0;
        cnt[free_slot]  <= '0;
        ovf[free_slot]  <= 1'b0;
      end
      if (in_ok) begin
        if (in_full) ovf[is] <= 1'b1;
        else         cnt[is] <= in_cnt + CW'(1);
      end
    end
  end

  // R3: a slot's word count never exceeds its capacity
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    rd_count <= CW'(WPS));
  // R8: the forwarder only frees a slot that holds an accepted crossing
  assert_free_busy_R8: assert property (@(posedge clk) disable iff (rst)
    free_valid |-> busy[free_slot]);
  // R6: a word meeting its own verdict in the same cycle counts as late
  assert_same_cycle_late_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_valid && in_xing == dec_xing) |=> late_count != $past(late_count));
endmodule

// File: rtl/xbuf_fifo.sv
// Queue of accepted crossing numbers, in verdict order.
module xbuf_fifo #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int D = 1 << AW;

  logic [W-1:0]  q [D];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   n;

  assign head  = q[rp];
  assign empty = (n == '0);
  assign full  = (n == (AW+1)'(D));

  always_ff @(posedge clk) begin
    if (push && !full) q[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
      n  <= '0;
    end else begin
      if (push && !full) wp <= wp + AW'(1);
      if (pop && !empty) rp <= rp + AW'(1);
      n <= n + (AW+1)'(push && !full) - (AW+1)'(pop && !empty);
    end
  end

  // R5: at most one accepted crossing per slot, so the queue never overflows
  assert_fifo_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
endmodule

// File: rtl/xbuf_fwd.sv
// Forwarder: emits header then payload for each queued crossing, frees the slot.
module xbuf_fwd
  import xbuf_pkg::*;
#(
  parameter int XW  = 8,
  parameter int DW  = 16,
  parameter int SB  = 4,
  parameter int WPS = 4,
  localparam int CW = $clog2(WPS + 1),
  localparam int IW = $clog2(WPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          q_empty,
  input  logic [XW-1:0] q_head,
  output logic          q_pop,
  output logic [SB-1:0] rd_slot,
  output logic [IW-1:0] rd_idx,
  input  logic [DW-1:0] rd_word,
  input  logic [CW-1:0] rd_count,
  input  logic          rd_ovf,
  output logic          free_valid,
  output logic [SB-1:0] free_slot,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop
);
  fw_state_e     state;
  logic [SB-1:0] cur_slot;
  logic [IW-1:0] idx;
  logic          adv, last, hdr_go;

  always_comb begin
    adv        = !out_valid || out_ready;
    rd_slot    = (state == FW_IDLE) ? q_head[SB-1:0] : cur_slot;
    rd_idx     = idx;
    last       = (CW'(idx) + CW'(1)) == rd_count;
    hdr_go     = (state == FW_IDLE) && !q_empty && adv;
    q_pop      = hdr_go;
    free_valid = (hdr_go && rd_count == '0) || (state == FW_PAY && adv && last);
    free_slot  = rd_slot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= FW_IDLE;
      cur_slot  <= '0;
      idx       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
    end else if (adv) begin
      if (state == FW_IDLE) begin
        if (!q_empty) begin
          out_valid <= 1'b1;
          out_data  <= DW'({rd_ovf, rd_count, q_head});
          out_sop   <= 1'b1;
          out_eop   <= (rd_count == '0);
          cur_slot  <= q_head[SB-1:0];
          idx       <= '0;
          state     <= (rd_count == '0) ? FW_IDLE : FW_PAY;
        end else begin
          out_valid <= 1'b0;
        end
      end else begin
        out_valid <= 1'b1;
        out_data  <= rd_word;
        out_sop   <= 1'b0;
        out_eop   <= last;
        idx       <= idx + IW'(1);
        if (last) state <= FW_IDLE;
      end
    end
  end

  // R7: a stalled word stays put
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));
  // R4: after an end-of-frame word the next word is a header
  assert_frame_start_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_eop) |=> (!out_valid || out_sop));
endmodule

// File: rtl/xing_keep_buffer.sv
// Top: crossing-indexed store with delayed keep/drop release.
// XING_W must exceed SLOT_BITS; WORDS_PER_SLOT must be a power of two;
// DATA_W must hold XING_W + clog2(WORDS_PER_SLOT+1) + 1 header bits.
module xing_keep_buffer #(
  parameter int XING_W         = 8,
  parameter int DATA_W         = 16,
  parameter int SLOT_BITS      = 4,
  parameter int WORDS_PER_SLOT = 4,
  parameter int LATE_W         = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [XING_W-1:0] in_xing,
  input  logic [DATA_W-1:0] in_data,
  input  logic              dec_valid,
  input  logic [XING_W-1:0] dec_xing,
  input  logic              dec_accept,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [LATE_W-1:0] late_count,
  output logic              reuse_err
);
  localparam int CW = $clog2(WORDS_PER_SLOT + 1);
  localparam int IW = $clog2(WORDS_PER_SLOT);

  logic              push_valid, q_pop, q_empty, q_full, rd_ovf, free_valid;
  logic [XING_W-1:0] push_xing, q_head;
  logic [SLOT_BITS-1:0] rd_slot, free_slot;
  logic [IW-1:0]     rd_idx;
  logic [DATA_W-1:0] rd_word;
  logic [CW-1:0]     rd_count;

  xbuf_slots #(.XW(XING_W), .DW(DATA_W), .SB(SLOT_BITS), .WPS(WORDS_PER_SLOT), .LW(LATE_W)) u_slots (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_xing(in_xing), .in_data(in_data),
    .dec_valid(dec_valid), .dec_xing(dec_xing), .dec_accept(dec_accept),
    .push_valid(push_valid), .push_xing(push_xing),
    .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_word(rd_word), .rd_count(rd_count), .rd_ovf(rd_ovf),
    .free_valid(free_valid), .free_slot(free_slot),
    .late_count(late_count), .reuse_err(reuse_err)
  );

  xbuf_fifo #(.W(XING_W), .AW(SLOT_BITS)) u_queue (
    .clk(clk), .rst(rst),
    .push(push_valid), .din(push_xing), .pop(q_pop),
    .head(q_head), .empty(q_empty), .full(q_full)
  );

  xbuf_fwd #(.XW(XING_W), .DW(DATA_W), .SB(SLOT_BITS), .WPS(WORDS_PER_SLOT)) u_fwd (
    .clk(clk), .rst(rst),
    .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
    .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_word(rd_word), .rd_count(rd_count), .rd_ovf(rd_ovf),
    .free_valid(free_valid), .free_slot(free_slot),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );
endmodule

// File: tb/tb_xing_keep_buffer.sv
`timescale 1ns/1ps
module tb_xing_keep_buffer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, dec_valid = 1'b0, dec_accept = 1'b0, out_ready = 1'b1;
  logic [7:0]  in_xing = '0, dec_xing = '0;
  logic [15:0] in_data = '0;
  logic        out_valid, out_sop, out_eop, reuse_err;
  logic [15:0] out_data, late_count;

  always #2 clk = ~clk;

  xing_keep_buffer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_xing(in_xing), .in_data(in_data),
    .dec_valid(dec_valid), .dec_xing(dec_xing), .dec_accept(dec_accept),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .late_count(late_count), .reuse_err(reuse_err)
  );

  int nchk = 0, nfail = 0;
  logic [15:0] exd [64]; logic exs [64]; logic exe [64]; int nexp = 0;
  logic [15:0] cpd [64]; logic cps [64]; logic cpe [64]; int ncap = 0;

  // {crossing, words sent, accept}
  localparam logic [12:0] VEC [8] = '{
    {8'd1, 4'd2, 1'b1}, {8'd2, 4'd3, 1'b0}, {8'd3, 4'd0, 1'b1}, {8'd4, 4'd6, 1'b1},
    {8'd5, 4'd4, 1'b1}, {8'd6, 4'd1, 1'b0}, {8'd7, 4'd1, 1'b1}, {8'd8, 4'd3, 1'b1}};

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready && ncap < 64) begin
      cpd[ncap] = out_data; cps[ncap] = out_sop; cpe[ncap] = out_eop;
      ncap = ncap + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [7:0] x, input logic [7:0] k);
    @(posedge clk); #1;
    in_valid = 1'b1; in_xing = x; in_data = {x, k};
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_dec(input logic [7:0] x, input bit acc);
    @(posedge clk); #1;
    dec_valid = 1'b1; dec_xing = x; dec_accept = acc;
    @(posedge clk); #1;
    dec_valid = 1'b0;
  endtask

  task automatic add_frame(input logic [7:0] x, input int n);
    int c = (n > 4) ? 4 : n;
    exd[nexp] = {4'b0, (n > 4), 3'(c), x}; exs[nexp] = 1'b1; exe[nexp] = (c == 0); nexp++;
    for (int k = 0; k < c; k++) begin
      exd[nexp] = {x, 8'(k)}; exs[nexp] = 1'b0; exe[nexp] = (k == c - 1); nexp++;
    end
  endtask

  task automatic check_stream();
    for (int w = 0; w < 300 && ncap < nexp; w++) @(negedge clk);
    repeat (10) @(negedge clk);
    check(ncap == nexp, "R2 R5 frame count", 32'(ncap), 32'(nexp));
    for (int i = 0; i < nexp && i < ncap; i++) begin
      if (exs[i]) check(cpd[i] == exd[i] && cps[i] && cpe[i] == exe[i],
                        exd[i][11] ? "R3 header" : "R4 header", {15'b0, cpe[i], cpd[i]}, {15'b0, exe[i], exd[i]});
      else check(cpd[i] == exd[i] && !cps[i] && cpe[i] == exe[i], "R1 payload",
                 {15'b0, cpe[i], cpd[i]}, {15'b0, exe[i], exd[i]});
    end
    ncap = 0; nexp = 0;
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(!out_valid && !reuse_err && late_count == 0, "R10 reset", {out_valid, reuse_err, late_count}, 0);

    // Vector table: words then verdict per crossing
    for (int v = 0; v < 8; v++) begin
      for (int k = 0; k < int'(VEC[v][4:1]); k++) send_word(VEC[v][12:5], 8'(k));
      send_dec(VEC[v][12:5], VEC[v][0]);
      if (VEC[v][0]) add_frame(VEC[v][12:5], int'(VEC[v][4:1]));
    end
    check_stream();

    // R6: late words (same crossing, older crossing, same-cycle verdict)
    send_word(8'd8, 8'd0); @(negedge clk);
    check(late_count == 1, "R6 same crossing late", late_count, 1);
    send_word(8'd3, 8'd0); @(negedge clk);
    check(late_count == 2, "R6 older crossing late", late_count, 2);
    @(posedge clk); #1;
    in_valid = 1'b1; in_xing = 8'd9; in_data = 16'h0900;
    dec_valid = 1'b1; dec_xing = 8'd9; dec_accept = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; dec_valid = 1'b0;
    @(negedge clk);
    check(late_count == 3, "R6 same-cycle verdict late", late_count, 3);
    add_frame(8'd9, 0);
    check_stream();

    // R7: backpressure hold
    @(posedge clk); #1; out_ready = 1'b0;
    send_word(8'd10, 8'd0); send_word(8'd10, 8'd1); send_dec(8'd10, 1'b1);
    repeat (3) @(negedge clk);
    check(out_valid && out_sop && out_data == 16'h020A, "R7 header presented", out_data, 16'h020A);
    repeat (4) @(negedge clk);
    check(out_valid && out_sop && out_data == 16'h020A, "R7 header held", out_data, 16'h020A);

    // R9: reuse of pending slot 10 by crossing 26
    send_word(8'd26, 8'd7); @(negedge clk);
    check(reuse_err == 1'b1, "R9 reuse error pulse", reuse_err, 1);
    @(negedge clk);
    check(reuse_err == 1'b0, "R9 pulse ends", reuse_err, 0);
    @(posedge clk); #1; out_ready = 1'b1;
    add_frame(8'd10, 2);
    check_stream();

    // R8: freed slot starts empty for the next crossing
    send_word(8'd26, 8'd0); send_dec(8'd26, 1'b1);
    add_frame(8'd26, 1);
    check_stream();

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule